// File: doc/BRIEF.md
# Display Pixel Source Switch

This block sits at the end of a display pixel pipeline and decides, one pixel at a time, whether the screen shows the direct-color stream or a palette-graphics stream. The palette side is either VGA pass-through data or overlay data. The choice depends on four things: a port-select pin sampled on the pixel load clock, a rectangular auxiliary window, a color-key match flag, and a small control register. That register gates the port-select and window terms and then applies a polarity bit.

The window result and the color-key flag are combined by OR, so either one alone can force palette graphics. VGA data is chosen only when VGA switching is enabled and the multiplex ratio is 1:1. Otherwise palette graphics means overlay. If the overlay path is needed but the current mode has no overlay capability, the block outputs a zero pixel and raises an error flag.

All three data streams and the selection strobes pass through one shared delay line, so they stay aligned. Configuration writes land in staging registers and are copied into the working set only during blanking. This keeps a line from changing source part way through.

Top module: `pix_src_switch`

## Requirements
- R1: After reset, the outputs read pixel 0 with tag 3 and no error. With no configuration written, active pixels show VGA data (tag 1), because the reset settings are control = 3'b001, VGA enable on and ratio 1:1.
- R2: The window term is sw = ((portSel & ctl[2]) | (inWin & ctl[1])) ^ ctl[0]. If sw = 0 and keyMatch = 0, the pixel shows directPix with tag 0.
- R3: If keyMatch = 1, palette graphics are shown even when sw = 0.
- R4: With ctl[2] = ctl[1] = 0, ctl[0] alone selects direct color (0) or palette graphics (1), whatever portSel and the window say.
- R5: Palette graphics show vgaPix with tag 1 only when mode bit 0 (VGA enable) is 1 and mode bits 2:1 (multiplex ratio) are 0. Otherwise they show ovlPix with tag 2.
- R6: If palette graphics need the overlay path and mode bit 3 (overlay capable) is 0, the outputs are pixel 0, tag 3 and errFlag = 1.
- R7: inWin is 1 when the pixel column x and row y satisfy xStart <= x <= xEnd and yStart <= y <= yEnd, with inclusive bounds. Column x starts at 0 on the first active pixel after hBlank. Row y is 0 on the first line after vBlank and increments at each rising edge of hBlank.
- R8: A configuration write sets a staging register. Addresses are 0 = ctl[2:0], 1 = mode, 2 = xStart, 3 = xEnd, 4 = yStart, 5 = yEnd. The staged value moves into use at a clock edge where hBlank or vBlank is 1, and never during active video.
- R9: The output for the inputs presented in a given cycle appears DEPTH clock edges later. The three data streams and the selection strobes stay aligned.
- R10: During blanking (hBlank or vBlank = 1), the outputs are pixel 0, tag 3 and errFlag = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel load clock |
| rstN | input | 1 | Active-low synchronous reset |
| hBlank | input | 1 | Horizontal blanking |
| vBlank | input | 1 | Vertical blanking |
| portSel | input | 1 | Port-select pin, sampled each pixel |
| keyMatch | input | 1 | Color-key match for this pixel |
| directPix | input | PIX_W | Direct-color pixel |
| vgaPix | input | PIX_W | VGA pass-through pixel |
| ovlPix | input | PIX_W | Overlay pixel |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 3 | Configuration register address |
| cfgData | input | COORD_W | Configuration write data |
| outPix | output | PIX_W | Selected pixel |
| outSrc | output | 2 | Source tag: 0 direct, 1 VGA, 2 overlay, 3 none |
| errFlag | output | 1 | Overlay requested with no overlay capability |

## Verification
The hardest case to reach is a configuration write that lands in the middle of a line. Its staged value has to stay unused until the next blanking cycle, while the window counters keep running. The stimulus drives random writes to the control and mode registers during active pixels, and a bench model follows the staging and activation separately. Every later pixel of that line therefore checks that the old setting is still in force. Random frames also sweep all eight control values across the four mode combinations, with random window bounds, so the inclusive edges of the window fall on live pixels.

// File: rtl/pss_pkg.sv
package pss_pkg;
  typedef enum logic [1:0] {
    SRC_DIRECT  = 2'd0,
    SRC_VGA     = 2'd1,
    SRC_OVERLAY = 2'd2,
    SRC_NONE    = 2'd3
  } pixSrc_e;

  // strobes from control to datapath, one set per pixel
  typedef struct packed {
    logic active;
    logic pickPal;
    logic pickVga;
    logic ovlMissing;
  } selStrobe_t;

  localparam int STROBE_W = $bits(selStrobe_t);

  localparam logic [2:0] ADDR_CTL  = 3'd0;
  localparam logic [2:0] ADDR_MODE = 3'd1;
  localparam logic [2:0] ADDR_XS   = 3'd2;
  localparam logic [2:0] ADDR_XE   = 3'd3;
  localparam logic [2:0] ADDR_YS   = 3'd4;
  localparam logic [2:0] ADDR_YE   = 3'd5;
endpackage

// File: rtl/pss_ctrl.sv
module pss_ctrl
  import pss_pkg::*;
#(
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hBlank,
  input  logic               vBlank,
  input  logic               portSel,
  input  logic               keyMatch,
  input  logic               cfgWe,
  input  logic [2:0]         cfgAddr,
  input  logic [COORD_W-1:0] cfgData,
  output selStrobe_t         stb
);
  localparam logic [2:0] CTL_RESET = 3'b001;

  // staging registers
  logic [2:0]         stCtl;
  logic               stVgaEn, stOvlCap;
  logic [1:0]         stRatio;
  logic [COORD_W-1:0] stXs, stXe, stYs, stYe;
  // working registers
  logic [2:0]         actCtl;
  logic               actVgaEn, actOvlCap;
  logic [1:0]         actRatio;
  logic [COORD_W-1:0] actXs, actXe, actYs, actYe;

  logic [COORD_W-1:0] xCnt, yCnt;
  logic               prevH;
  logic               blank, active, inWin, winSw, palSel, vgaOk;

  assign blank  = hBlank | vBlank;
  assign active = ~blank;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stCtl <= CTL_RESET; stVgaEn <= 1'b1; stRatio <= '0; stOvlCap <= 1'b0;
      stXs <= '0; stXe <= '0; stYs <= '0; stYe <= '0;
    end else if (cfgWe) begin
      unique case (cfgAddr)
        ADDR_CTL:  stCtl <= cfgData[2:0];
        ADDR_MODE: begin
          stVgaEn  <= cfgData[0];
          stRatio  <= cfgData[2:1];
          stOvlCap <= cfgData[3];
        end
        ADDR_XS: stXs <= cfgData;
        ADDR_XE: stXe <= cfgData;
        ADDR_YS: stYs <= cfgData;
        ADDR_YE: stYe <= cfgData;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actCtl <= CTL_RESET; actVgaEn <= 1'b1; actRatio <= '0; actOvlCap <= 1'b0;
      actXs <= '0; actXe <= '0; actYs <= '0; actYe <= '0;
    end else if (blank) begin
      actCtl <= stCtl; actVgaEn <= stVgaEn; actRatio <= stRatio; actOvlCap <= stOvlCap;
      actXs <= stXs; actXe <= stXe; actYs <= stYs; actYe <= stYe;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xCnt <= '0; yCnt <= '0; prevH <= 1'b1;
    end else begin
      prevH <= hBlank;
      if (hBlank)      xCnt <= '0;
      else if (active) xCnt <= xCnt + 1'b1;
      if (vBlank)                yCnt <= '0;
      else if (hBlank && !prevH) yCnt <= yCnt + 1'b1;
    end
  end

  assign inWin  = active && (xCnt >= actXs) && (xCnt <= actXe)
                         && (yCnt >= actYs) && (yCnt <= actYe);
  assign winSw  = ((portSel & actCtl[2]) | (inWin & actCtl[1])) ^ actCtl[0];
  assign palSel = winSw | keyMatch;
  assign vgaOk  = actVgaEn && (actRatio == 2'd0);

  always_comb begin
    stb.active     = active;
    stb.pickPal    = palSel;
    stb.pickVga    = palSel & vgaOk;
    stb.ovlMissing = palSel & ~vgaOk & ~actOvlCap;
  end

  // R8: working set only changes after a blanking cycle
  a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(blank) |-> $stable({actCtl, actVgaEn, actRatio, actOvlCap, actXs, actXe, actYs, actYe}));
  // R7: column restarts after horizontal blanking
  a_r7_x_restart: assert property (@(posedge clk) disable iff (!rstN)
    $past(hBlank) |-> (xCnt == '0));
  // R7: row restarts after vertical blanking
  a_r7_y_restart: assert property (@(posedge clk) disable iff (!rstN)
    $past(vBlank) |-> (yCnt == '0));
  // R5/R6: VGA and missing-overlay exclude each other and imply palette
  a_r5_pal_implied: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pickVga || stb.ovlMissing) |-> (stb.pickPal && $onehot0({stb.pickVga, stb.ovlMissing})));
endmodule

// File: rtl/pss_datapath.sv
module pss_datapath
  import pss_pkg::*;
#(
  parameter int PIX_W = 24,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  selStrobe_t       stb,
  input  logic [PIX_W-1:0] directPix,
  input  logic [PIX_W-1:0] vgaPix,
  input  logic [PIX_W-1:0] ovlPix,
  output logic [PIX_W-1:0] outPix,
  output pixSrc_e          outSrc,
  output logic             errFlag
);
  localparam int BUND_W = STROBE_W + 3 * PIX_W;

  logic [BUND_W-1:0] bundIn, bundTail;
  selStrobe_t        tStb;
  logic [PIX_W-1:0]  tDir, tVga, tOvl;

  assign bundIn = {stb, directPix, vgaPix, ovlPix};

  generate
    if (DEPTH > 1) begin : g_delay
      logic [BUND_W-1:0] dly [DEPTH-1];
      always_ff @(posedge clk) begin
        if (!rstN) begin
          for (int s = 0; s < DEPTH - 1; s++) dly[s] <= '0;
        end else begin
          dly[0] <= bundIn;
          for (int s = 1; s < DEPTH - 1; s++) dly[s] <= dly[s-1];
        end
      end
      assign bundTail = dly[DEPTH-2];
    end else begin : g_direct
      assign bundTail = bundIn;
    end
  endgenerate

  assign {tStb, tDir, tVga, tOvl} = bundTail;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outPix <= '0; outSrc <= SRC_NONE; errFlag <= 1'b0;
    end else if (!tStb.active) begin
      outPix <= '0; outSrc <= SRC_NONE; errFlag <= 1'b0;
    end else if (tStb.ovlMissing) begin
      outPix <= '0; outSrc <= SRC_NONE; errFlag <= 1'b1;
    end else if (tStb.pickVga) begin
      outPix <= tVga; outSrc <= SRC_VGA; errFlag <= 1'b0;
    end else if (tStb.pickPal) begin
      outPix <= tOvl; outSrc <= SRC_OVERLAY; errFlag <= 1'b0;
    end else begin
      outPix <= tDir; outSrc <= SRC_DIRECT; errFlag <= 1'b0;
    end
  end

  // R6: an error always carries a zero pixel and no source
  a_r6_err_zero: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> (outPix == '0 && outSrc == SRC_NONE));
  // R10: no source means a zero pixel
  a_r10_none_zero: assert property (@(posedge clk) disable iff (!rstN)
    (outSrc == SRC_NONE) |-> (outPix == '0));
endmodule

// File: rtl/pix_src_switch.sv
module pix_src_switch
  import pss_pkg::*;
#(
  parameter int PIX_W   = 24,
  parameter int COORD_W = 12,
  parameter int DEPTH   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hBlank,
  input  logic               vBlank,
  input  logic               portSel,
  input  logic               keyMatch,
  input  logic [PIX_W-1:0]   directPix,
  input  logic [PIX_W-1:0]   vgaPix,
  input  logic [PIX_W-1:0]   ovlPix,
  input  logic               cfgWe,
  input  logic [2:0]         cfgAddr,
  input  logic [COORD_W-1:0] cfgData,
  output logic [PIX_W-1:0]   outPix,
  output logic [1:0]         outSrc,
  output logic               errFlag
);
  selStrobe_t stb;
  pixSrc_e    srcTag;

  pss_ctrl #(.COORD_W(COORD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .hBlank(hBlank), .vBlank(vBlank),
    .portSel(portSel), .keyMatch(keyMatch),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData), .stb(stb)
  );

  pss_datapath #(.PIX_W(PIX_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .directPix(directPix), .vgaPix(vgaPix), .ovlPix(ovlPix),
    .outPix(outPix), .outSrc(srcTag), .errFlag(errFlag)
  );

  assign outSrc = srcTag;
endmodule

// File: tb/pix_src_switch_test.sv
module pix_src_switch_test;
  localparam int PIX_W = 24;
  localparam int COORD_W = 12;
  localparam int DEPTH = 2;
  localparam int ACT = 16;
  localparam int HB = 4;
  localparam int NL = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hBlank = 1'b1, vBlank = 1'b1, portSel = 1'b0, keyMatch = 1'b0;
  logic [PIX_W-1:0] directPix = '0, vgaPix = '0, ovlPix = '0;
  logic cfgWe = 1'b0;
  logic [2:0] cfgAddr = '0;
  logic [COORD_W-1:0] cfgData = '0;
  logic [PIX_W-1:0] outPix;
  logic [1:0] outSrc;
  logic errFlag;

  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pix_src_switch #(.PIX_W(PIX_W), .COORD_W(COORD_W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .hBlank(hBlank), .vBlank(vBlank),
    .portSel(portSel), .keyMatch(keyMatch),
    .directPix(directPix), .vgaPix(vgaPix), .ovlPix(ovlPix),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .outPix(outPix), .outSrc(outSrc), .errFlag(errFlag)
  );

  // bench model: staged and working configuration, counters
  int sCtl, sVga, sRat, sOvl, sXs, sXe, sYs, sYe;
  int aCtl, aVga, aRat, aOvl, aXs, aXe, aYs, aYe;
  int mX, mY;
  bit mPrevH, touched;

  // expected history ring
  logic [PIX_W-1:0] ePix [8];
  logic [1:0]       eSrc [8];
  logic             eErr [8];
  string            eReq [8];
  bit               eVal [8];
  int cyc = 0;

  function automatic bit stagedDiffers();
    return (sCtl != aCtl) || (sVga != aVga) || (sRat != aRat) || (sOvl != aOvl);
  endfunction

  task automatic check(input string req, input longint act, input longint exp, input string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic modelReset();
    sCtl = 1; sVga = 1; sRat = 0; sOvl = 0; sXs = 0; sXe = 0; sYs = 0; sYe = 0;
    aCtl = 1; aVga = 1; aRat = 0; aOvl = 0; aXs = 0; aXe = 0; aYs = 0; aYe = 0;
    mX = 0; mY = 0; mPrevH = 1; touched = 0;
    for (int i = 0; i < 8; i++) eVal[i] = 0;
  endtask

  // one pixel cycle; called at a negedge
  task automatic step(input bit h, input bit v, input bit ps, input bit key,
                      input bit we, input int ad, input int dat);
    int slot;
    bit act, win, sw, pal;
    logic [PIX_W-1:0] d, g, o;
    string req;
    // R9: outputs compared DEPTH edges after their inputs
    if (cyc >= DEPTH) begin
      slot = (cyc - DEPTH) % 8;
      if (eVal[slot]) begin
        check(eReq[slot], outSrc, eSrc[slot], "source tag");
        check(eReq[slot], outPix, ePix[slot], "pixel");
        check(eReq[slot], errFlag, eErr[slot], "error flag");
      end
    end
    d = PIX_W'($urandom); g = PIX_W'($urandom); o = PIX_W'($urandom);
    slot = cyc % 8;
    act = !h && !v;
    win = act && mX >= aXs && mX <= aXe && mY >= aYs && mY <= aYe;
    sw  = ((ps && aCtl[2]) || (win && aCtl[1])) ^ aCtl[0];
    pal = sw || key;
    eVal[slot] = 1; eErr[slot] = 0;
    if (!act) begin
      ePix[slot] = '0; eSrc[slot] = 2'd3; req = "R10";
    end else if (!pal) begin
      ePix[slot] = d; eSrc[slot] = 2'd0;
      req = (aCtl[2:1] == 0) ? "R4" : ((win && aCtl[1]) ? "R7" : "R2");
    end else if (aVga != 0 && aRat == 0) begin
      ePix[slot] = g; eSrc[slot] = 2'd1;
      req = !touched ? "R1" : (!sw ? "R3" : "R5");
    end else if (aOvl != 0) begin
      ePix[slot] = o; eSrc[slot] = 2'd2; req = !sw ? "R3" : "R5";
    end else begin
      ePix[slot] = '0; eSrc[slot] = 2'd3; eErr[slot] = 1; req = "R6";
    end
    if (act && stagedDiffers()) req = "R8";
    eReq[slot] = req;
    hBlank = h; vBlank = v; portSel = ps; keyMatch = key;
    directPix = d; vgaPix = g; ovlPix = o;
    cfgWe = we; cfgAddr = 3'(ad); cfgData = COORD_W'(dat);
    // model the clock edge
    if (!act) begin
      aCtl = sCtl; aVga = sVga; aRat = sRat; aOvl = sOvl;
      aXs = sXs; aXe = sXe; aYs = sYs; aYe = sYe;
    end
    if (we) begin
      touched = 1;
      case (ad)
        0: sCtl = dat & 7;
        1: begin sVga = dat & 1; sRat = (dat >> 1) & 3; sOvl = (dat >> 3) & 1; end
        2: sXs = dat;
        3: sXe = dat;
        4: sYs = dat;
        5: sYe = dat;
        default: ;
      endcase
    end
    if (h) mX = 0; else if (act) mX++;
    if (v) mY = 0; else if (h && !mPrevH) mY++;
    mPrevH = h;
    @(negedge clk);
    cyc++;
  endtask

  task automatic wr(input int ad, input int dat);
    step(1, 1, 1'($urandom), 1'($urandom), 1, ad, dat);
  endtask

  // one line; optional write in the middle of active video
  task automatic line(input bit v, input bit midWe, input int ad, input int dat);
    for (int p = 0; p < ACT; p++)
      step(0, v, 1'($urandom), ($urandom % 5) == 0, midWe && p == ACT / 2, ad, dat);
    for (int p = 0; p < HB; p++)
      step(1, v, 1'($urandom), 1'($urandom), 0, 0, 0);
  endtask

  task automatic frame(input bit midWe);
    for (int p = 0; p < 6; p++) step(1, 1, 1'($urandom), 1'($urandom), 0, 0, 0);
    for (int l = 0; l < NL; l++)
      line(0, midWe && l == 2, $urandom % 2, $urandom % 16);
  endtask

  initial begin
    void'($urandom(32'd4711));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state of the outputs
    check("R1", outPix, 0, "reset pixel");
    check("R1", outSrc, 3, "reset tag");
    check("R1", errFlag, 0, "reset error");
    // R1: defaults give VGA pass-through without programming
    frame(0);
    // R7: window on exact edges, R2/R4 sweep all control values and modes
    for (int sc = 0; sc < 32; sc++) begin
      int xs, ys;
      xs = $urandom % 12; ys = $urandom % 4;
      wr(2, xs); wr(3, xs + ($urandom % 5));
      wr(4, ys); wr(5, ys + ($urandom % 3));
      wr(0, sc % 8);
      case ((sc / 8) % 4)
        0: wr(1, 4'b0001);
        1: wr(1, 4'b1101);
        2: wr(1, 4'b1000);
        default: wr(1, 4'b0000);
      endcase
      frame(0);
    end
    // R8: writes landing in active video must wait for blanking
    for (int k = 0; k < 12; k++) begin
      wr(0, k % 8); wr(1, (k % 2) ? 4'b0001 : 4'b1000);
      frame(1);
    end
    // R6: overlay path missing with VGA disabled, forced palette
    wr(0, 1); wr(1, 4'b0000); frame(0);
    // R4: both gates off, polarity low gives direct color
    wr(0, 0); frame(0);
    repeat (DEPTH + 1) step(1, 1, 0, 0, 0, 0, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL R9 watchdog: actual not finished, expected finished by cycle 150000");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule